// File: doc/BRIEF.md
# Two-Class Switch Allocator with Single-Cycle Bypass

This block decides, every cycle, which input virtual channels of a five-port mesh router may send a flit across the crossbar, and to which output. Each input VC offers one request: a target output, a priority-class bit, a tail marker and a flag saying the downstream VC has buffer space. Requests from expedited (high-class) packets are served before normal ones. This holds both when an input port chooses one of its VCs and when an output port chooses one of the competing inputs. Inside each class, both choices rotate round-robin.

A second request path serves flits that are still arriving on a link and have not yet been written into a VC buffer. An expedited arrival whose output has no buffered competitor is granted on the spot. That lets the flit skip the buffer write, route, VC and switch allocation stages and cross in the following cycle. Once a packet's head flit takes an output through either path, the output stays reserved for that VC until the tail flit has been granted, so wormhole packets never interleave.

Grants are combinational from the current requests and the allocator state. The round-robin pointers and output reservations update at the clock edge.

Top module: `prio_switch_alloc`

## Requirements
- R1: After reset no output is reserved and every round-robin pointer is 0, so the lowest-numbered eligible requester in a class wins first; with no request, no grant is driven.
- R2: A buffered request is eligible only if its valid bit and its credit bit are both 1 and its output code is 0 to 4; codes 5 to 7 are ignored.
- R3: Each input port receives at most one grant per cycle, whether buffered or bypass, and each output port grants at most one source per cycle.
- R4: A request whose class bit is 1 always wins over one whose class bit is 0, both when choosing a VC inside an input port and when choosing an input at an output.
- R5: At each output and for each class, the search starts at the port pointer; after a buffered grant in that class, the pointer moves to the granted port index plus 1, wrapping after port 4.
- R6: At each input and for each class, the VC search starts at the VC pointer; after a buffered grant of that input, the pointer of the granted class moves to the granted VC plus 1, wrapping after VC 3.
- R7: A grant whose tail bit is 0 reserves that output for the granted (port, VC) pair. While the output is reserved, requests and arrivals from any other pair are ineligible for it. A granted tail flit releases the reservation at the next clock edge.
- R8: An arrival is granted bypass only if all of the following hold: it is valid, its class bit is 1, its credit bit is 1 and its output code is legal; its input port has no buffered valid request; no eligible buffered request targets that output; and the output is free or reserved for the arrival's own (port, VC).
- R9: When several bypass arrivals want the same output, the lowest port index wins. A bypass grant reserves or releases the output as in R7 and leaves all round-robin pointers unchanged.
- R10: Grants, the per-output source index and the bypass flag reflect the inputs in the same cycle; state changes only at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 20 | Buffered request valid, index port*4+vc |
| reqOut | input | 20x3 | Target output code per input VC |
| reqHi | input | 20 | Class bit, 1 = expedited |
| reqTail | input | 20 | Head-of-buffer flit is a tail |
| reqCredit | input | 20 | Downstream VC has at least one credit |
| arrValid | input | 5 | Arriving flit present on the input link |
| arrVc | input | 5x2 | VC of the arriving flit |
| arrOut | input | 5x3 | Target output code of the arriving flit |
| arrHi | input | 5 | Arriving flit is expedited |
| arrTail | input | 5 | Arriving flit is a tail |
| arrCredit | input | 5 | Downstream credit for the arriving flit |
| vcGnt | output | 20 | Buffered grant per input VC |
| bypGnt | output | 5 | Bypass grant per input port |
| outValid | output | 5 | Output port has a granted source |
| outSrc | output | 5x3 | Input port feeding each output |
| outBypass | output | 5 | Output grant comes from the bypass path |

## Verification
A reference model in the bench recomputes every grant from the stimulus each cycle, and the model is exercised with several pattern families. All VCs aiming at one output with mixed classes separates class ordering from rotation. Two-output contention with one class isolates the port and VC pointers. Illegal output codes mixed with missing credits show that only eligible requests are counted. Rare tails keep outputs reserved for long stretches, which exposes leaks from other VCs. Sparse buffered traffic under frequent arrivals opens bypass windows, with conflicts between arrivals for one output. A fully random phase mixes all of these.

// File: rtl/sa_pkg.sv
package sa_pkg;
  parameter int SA_PORTS = 5;
  parameter int SA_VCS = 4;
  localparam int SA_IN_VCS = SA_PORTS * SA_VCS;
  localparam int SA_PORT_W = (SA_PORTS > 1) ? $clog2(SA_PORTS) : 1;
  localparam int SA_VC_W = (SA_VCS > 1) ? $clog2(SA_VCS) : 1;

  // One strobe per output port, datapath -> control
  typedef struct packed {
    logic fire;
    logic byp;
    logic hi;
    logic tail;
    logic [SA_PORT_W-1:0] src;
    logic [SA_VC_W-1:0] vc;
  } sa_strobe_t;
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         any,
  output logic [W-1:0] idx
);
  // Scan offsets from far to near so the nearest requester from ptr wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      automatic int c = (int'(ptr) + k) % N;
      if (req[c]) begin
        any = 1'b1;
        idx = W'(c);
      end
    end
  end
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath import sa_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic [SA_IN_VCS-1:0] reqValid,
  input  logic [SA_IN_VCS-1:0][SA_PORT_W-1:0] reqOut,
  input  logic [SA_IN_VCS-1:0] reqHi,
  input  logic [SA_IN_VCS-1:0] reqTail,
  input  logic [SA_IN_VCS-1:0] reqCredit,
  input  logic [SA_PORTS-1:0] arrValid,
  input  logic [SA_PORTS-1:0][SA_VC_W-1:0] arrVc,
  input  logic [SA_PORTS-1:0][SA_PORT_W-1:0] arrOut,
  input  logic [SA_PORTS-1:0] arrHi,
  input  logic [SA_PORTS-1:0] arrTail,
  input  logic [SA_PORTS-1:0] arrCredit,
  input  logic [SA_PORTS-1:0] lockValid,
  input  logic [SA_PORTS-1:0][SA_PORT_W-1:0] lockSrc,
  input  logic [SA_PORTS-1:0][SA_VC_W-1:0] lockVc,
  input  logic [SA_PORTS-1:0][SA_PORT_W-1:0] outPtrHi,
  input  logic [SA_PORTS-1:0][SA_PORT_W-1:0] outPtrLo,
  input  logic [SA_PORTS-1:0][SA_VC_W-1:0] inPtrHi,
  input  logic [SA_PORTS-1:0][SA_VC_W-1:0] inPtrLo,
  output sa_strobe_t [SA_PORTS-1:0] strobe,
  output logic [SA_IN_VCS-1:0] vcGnt,
  output logic [SA_PORTS-1:0] bypGnt,
  output logic [SA_PORTS-1:0] outValid,
  output logic [SA_PORTS-1:0][SA_PORT_W-1:0] outSrc,
  output logic [SA_PORTS-1:0] outBypass
);
  localparam int NP = SA_PORTS;
  localparam int NV = SA_VCS;
  localparam int PW = SA_PORT_W;
  localparam int VW = SA_VC_W;

  logic [SA_IN_VCS-1:0] elig;
  logic [NP-1:0][NV-1:0] hiV, loV;
  logic [NP-1:0] pickValid, pickHi;
  logic [NP-1:0][VW-1:0] pickVc;
  logic [NP-1:0][PW-1:0] pickOut;
  logic [NP-1:0] winValid, winHi;
  logic [NP-1:0][PW-1:0] winSrc;
  logic [NP-1:0] bufAt, bufFor, bypCand, bypWinValid;
  logic [NP-1:0][PW-1:0] bypWinSrc;

  // Eligibility: valid, credit, legal output, output not reserved by another VC
  always_comb begin
    elig = '0;
    hiV = '0;
    loV = '0;
    for (int i = 0; i < SA_IN_VCS; i++) begin
      automatic int p = i / NV;
      automatic int v = i % NV;
      automatic int o = int'(reqOut[i]);
      automatic logic ok = 1'b0;
      if (reqValid[i] && reqCredit[i] && o < NP) begin
        ok = !lockValid[o] || (lockSrc[o] == PW'(p) && lockVc[o] == VW'(v));
      end
      elig[i] = ok;
      hiV[p][v] = ok && reqHi[i];
      loV[p][v] = ok && !reqHi[i];
    end
  end

  // Stage 1: each input port picks one VC, expedited class first
  for (genvar p = 0; p < NP; p++) begin : g_in
    logic hAny, lAny;
    logic [VW-1:0] hIdx, lIdx;
    sa_rr_arb #(.N(NV), .W(VW)) u_hi (.req(hiV[p]), .ptr(inPtrHi[p]), .any(hAny), .idx(hIdx));
    sa_rr_arb #(.N(NV), .W(VW)) u_lo (.req(loV[p]), .ptr(inPtrLo[p]), .any(lAny), .idx(lIdx));
    assign pickValid[p] = hAny | lAny;
    assign pickHi[p] = hAny;
    assign pickVc[p] = hAny ? hIdx : lIdx;
    assign pickOut[p] = reqOut[p * NV + int'(pickVc[p])];
  end

  // Stage 2: each output picks one input port, expedited class first
  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [NP-1:0] hReq, lReq;
    logic hAny, lAny;
    logic [PW-1:0] hIdx, lIdx;
    always_comb begin
      for (int q = 0; q < NP; q++) begin
        hReq[q] = pickValid[q] && pickHi[q] && pickOut[q] == PW'(o);
        lReq[q] = pickValid[q] && !pickHi[q] && pickOut[q] == PW'(o);
      end
    end
    sa_rr_arb #(.N(NP), .W(PW)) u_hi (.req(hReq), .ptr(outPtrHi[o]), .any(hAny), .idx(hIdx));
    sa_rr_arb #(.N(NP), .W(PW)) u_lo (.req(lReq), .ptr(outPtrLo[o]), .any(lAny), .idx(lIdx));
    assign winValid[o] = hAny | lAny;
    assign winHi[o] = hAny;
    assign winSrc[o] = hAny ? hIdx : lIdx;
  end

  // Bypass candidates: expedited arrivals facing no buffered competition
  always_comb begin
    bufAt = '0;
    bufFor = '0;
    bypCand = '0;
    bypWinValid = '0;
    bypWinSrc = '0;
    for (int i = 0; i < SA_IN_VCS; i++) begin
      if (reqValid[i]) bufAt[i / NV] = 1'b1;
      if (elig[i]) bufFor[reqOut[i]] = 1'b1;
    end
    for (int p = 0; p < NP; p++) begin
      automatic int o = int'(arrOut[p]);
      if (arrValid[p] && arrHi[p] && arrCredit[p] && o < NP && !bufAt[p]) begin
        bypCand[p] = !bufFor[o] &&
          (!lockValid[o] || (lockSrc[o] == PW'(p) && lockVc[o] == arrVc[p]));
      end
    end
    for (int o = 0; o < NP; o++) begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (bypCand[p] && arrOut[p] == PW'(o)) begin
          bypWinValid[o] = 1'b1;
          bypWinSrc[o] = PW'(p);
        end
      end
    end
  end

  // Grant outputs and control strobes
  always_comb begin
    vcGnt = '0;
    bypGnt = '0;
    for (int o = 0; o < NP; o++) begin
      automatic int s = int'(winSrc[o]);
      automatic int b = int'(bypWinSrc[o]);
      strobe[o] = '0;
      if (winValid[o]) begin
        strobe[o].fire = 1'b1;
        strobe[o].hi = winHi[o];
        strobe[o].src = winSrc[o];
        strobe[o].vc = pickVc[s];
        strobe[o].tail = reqTail[s * NV + int'(pickVc[s])];
        vcGnt[s * NV + int'(pickVc[s])] = 1'b1;
      end else if (bypWinValid[o]) begin
        strobe[o].fire = 1'b1;
        strobe[o].byp = 1'b1;
        strobe[o].hi = 1'b1;
        strobe[o].src = bypWinSrc[o];
        strobe[o].vc = arrVc[b];
        strobe[o].tail = arrTail[b];
        bypGnt[b] = 1'b1;
      end
      outValid[o] = strobe[o].fire;
      outSrc[o] = strobe[o].src;
      outBypass[o] = strobe[o].byp;
    end
  end

  for (genvar i = 0; i < SA_IN_VCS; i++) begin : g_chk_vc
    assert_grant_needs_credit_R2: assert property (@(posedge clk) disable iff (!rstN)
      vcGnt[i] |-> (reqValid[i] && reqCredit[i] && int'(reqOut[i]) < NP));
  end
  for (genvar p = 0; p < NP; p++) begin : g_chk_in
    assert_single_grant_per_input_R3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({bypGnt[p], vcGnt[p*NV +: NV]}));
    assert_bypass_only_expedited_R8: assert property (@(posedge clk) disable iff (!rstN)
      bypGnt[p] |-> (arrValid[p] && arrHi[p] && arrCredit[p] && reqValid[p*NV +: NV] == '0));
  end
  for (genvar o = 0; o < NP; o++) begin : g_chk_out
    assert_normal_loses_to_expedited_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[o].fire && !strobe[o].byp && !strobe[o].hi) |-> hiV[strobe[o].src] == '0);
  end
endmodule

// File: rtl/sa_control.sv
module sa_control import sa_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  sa_strobe_t [SA_PORTS-1:0] strobe,
  output logic [SA_PORTS-1:0] lockValid,
  output logic [SA_PORTS-1:0][SA_PORT_W-1:0] lockSrc,
  output logic [SA_PORTS-1:0][SA_VC_W-1:0] lockVc,
  output logic [SA_PORTS-1:0][SA_PORT_W-1:0] outPtrHi,
  output logic [SA_PORTS-1:0][SA_PORT_W-1:0] outPtrLo,
  output logic [SA_PORTS-1:0][SA_VC_W-1:0] inPtrHi,
  output logic [SA_PORTS-1:0][SA_VC_W-1:0] inPtrLo
);
  localparam int NP = SA_PORTS;
  localparam int NV = SA_VCS;

  function automatic logic [SA_PORT_W-1:0] nextPort(logic [SA_PORT_W-1:0] x);
    return (x == SA_PORT_W'(NP - 1)) ? '0 : x + 1'b1;
  endfunction

  function automatic logic [SA_VC_W-1:0] nextVc(logic [SA_VC_W-1:0] x);
    return (x == SA_VC_W'(NV - 1)) ? '0 : x + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockValid <= '0;
      lockSrc <= '0;
      lockVc <= '0;
      outPtrHi <= '0;
      outPtrLo <= '0;
      inPtrHi <= '0;
      inPtrLo <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (strobe[o].fire) begin
          lockValid[o] <= !strobe[o].tail;
          lockSrc[o] <= strobe[o].src;
          lockVc[o] <= strobe[o].vc;
          if (!strobe[o].byp) begin
            if (strobe[o].hi) begin
              outPtrHi[o] <= nextPort(strobe[o].src);
              inPtrHi[strobe[o].src] <= nextVc(strobe[o].vc);
            end else begin
              outPtrLo[o] <= nextPort(strobe[o].src);
              inPtrLo[strobe[o].src] <= nextVc(strobe[o].vc);
            end
          end
        end
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk
    assert_reserved_output_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
      (lockValid[o] && strobe[o].fire) |->
        (strobe[o].src == lockSrc[o] && strobe[o].vc == lockVc[o]));
    assert_tail_releases_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[o].fire && strobe[o].tail) |=> !lockValid[o]);
    assert_bypass_keeps_pointers_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[o].fire && strobe[o].byp) |=> ($stable(outPtrHi[o]) && $stable(outPtrLo[o])));
  end
endmodule

// File: rtl/prio_switch_alloc.sv
module prio_switch_alloc import sa_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic [SA_IN_VCS-1:0] reqValid,
  input  logic [SA_IN_VCS-1:0][SA_PORT_W-1:0] reqOut,
  input  logic [SA_IN_VCS-1:0] reqHi,
  input  logic [SA_IN_VCS-1:0] reqTail,
  input  logic [SA_IN_VCS-1:0] reqCredit,
  input  logic [SA_PORTS-1:0] arrValid,
  input  logic [SA_PORTS-1:0][SA_VC_W-1:0] arrVc,
  input  logic [SA_PORTS-1:0][SA_PORT_W-1:0] arrOut,
  input  logic [SA_PORTS-1:0] arrHi,
  input  logic [SA_PORTS-1:0] arrTail,
  input  logic [SA_PORTS-1:0] arrCredit,
  output logic [SA_IN_VCS-1:0] vcGnt,
  output logic [SA_PORTS-1:0] bypGnt,
  output logic [SA_PORTS-1:0] outValid,
  output logic [SA_PORTS-1:0][SA_PORT_W-1:0] outSrc,
  output logic [SA_PORTS-1:0] outBypass
);
  sa_strobe_t [SA_PORTS-1:0] strobe;
  logic [SA_PORTS-1:0] lockValid;
  logic [SA_PORTS-1:0][SA_PORT_W-1:0] lockSrc, outPtrHi, outPtrLo;
  logic [SA_PORTS-1:0][SA_VC_W-1:0] lockVc, inPtrHi, inPtrLo;

  sa_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOut(reqOut), .reqHi(reqHi), .reqTail(reqTail), .reqCredit(reqCredit),
    .arrValid(arrValid), .arrVc(arrVc), .arrOut(arrOut), .arrHi(arrHi), .arrTail(arrTail),
    .arrCredit(arrCredit),
    .lockValid(lockValid), .lockSrc(lockSrc), .lockVc(lockVc),
    .outPtrHi(outPtrHi), .outPtrLo(outPtrLo), .inPtrHi(inPtrHi), .inPtrLo(inPtrLo),
    .strobe(strobe), .vcGnt(vcGnt), .bypGnt(bypGnt),
    .outValid(outValid), .outSrc(outSrc), .outBypass(outBypass)
  );

  sa_control u_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lockValid(lockValid), .lockSrc(lockSrc), .lockVc(lockVc),
    .outPtrHi(outPtrHi), .outPtrLo(outPtrLo), .inPtrHi(inPtrHi), .inPtrLo(inPtrLo)
  );
endmodule

// File: tb/test_prio_switch_alloc.sv
module test_prio_switch_alloc;
  import sa_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NP = SA_PORTS;
  localparam int NV = SA_VCS;
  localparam int NI = SA_IN_VCS;
  localparam int PW = SA_PORT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NI-1:0] reqValid, reqHi, reqTail, reqCredit;
  logic [NI-1:0][PW-1:0] reqOut;
  logic [NP-1:0] arrValid, arrHi, arrTail, arrCredit;
  logic [NP-1:0][SA_VC_W-1:0] arrVc;
  logic [NP-1:0][PW-1:0] arrOut;
  logic [NI-1:0] vcGnt;
  logic [NP-1:0] bypGnt, outValid, outBypass;
  logic [NP-1:0][PW-1:0] outSrc;

  int checks = 0;
  int errors = 0;

  // Reference state
  int mLkV[NP], mLkP[NP], mLkC[NP];
  int mOpHi[NP], mOpLo[NP], mIpHi[NP], mIpLo[NP];
  // Expected results for the current cycle
  int eOv[NP], eOs[NP], eOb[NP], eV[NP], eH[NP], eT[NP];
  logic [NI-1:0] expVc;
  logic [NP-1:0] expByp;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_switch_alloc i_prio_switch_alloc (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOut(reqOut), .reqHi(reqHi), .reqTail(reqTail), .reqCredit(reqCredit),
    .arrValid(arrValid), .arrVc(arrVc), .arrOut(arrOut), .arrHi(arrHi), .arrTail(arrTail),
    .arrCredit(arrCredit),
    .vcGnt(vcGnt), .bypGnt(bypGnt), .outValid(outValid), .outSrc(outSrc), .outBypass(outBypass)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int o = 0; o < NP; o++) begin
      mLkV[o] = 0; mLkP[o] = 0; mLkC[o] = 0;
      mOpHi[o] = 0; mOpLo[o] = 0; mIpHi[o] = 0; mIpLo[o] = 0;
    end
  endtask

  function automatic bit freeFor(int o, int p, int v);
    return (mLkV[o] == 0) || (mLkP[o] == p && mLkC[o] == v);
  endfunction

  function automatic bit mElig(int p, int v);
    int i = p * NV + v;
    int o = int'(reqOut[i]);
    if (!reqValid[i] || !reqCredit[i] || o >= NP) return 1'b0;
    return freeFor(o, p, v);
  endfunction

  task automatic modelEval();
    bit pOk[NP]; bit pH[NP]; int pV[NP]; int pO[NP];
    bit anyBuf[NP]; bit bufFor[NP]; bit cand[NP];
    expVc = '0;
    expByp = '0;
    for (int p = 0; p < NP; p++) begin
      pOk[p] = 0; pH[p] = 0; pV[p] = 0; pO[p] = 0; anyBuf[p] = 0; bufFor[p] = 0; cand[p] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      for (int c = 1; c >= 0; c--) begin
        for (int k = 0; k < NV; k++) begin
          automatic int v = ((c == 1 ? mIpHi[p] : mIpLo[p]) + k) % NV;
          if (!pOk[p] && mElig(p, v) && int'(reqHi[p*NV+v]) == c) begin
            pOk[p] = 1; pH[p] = c[0]; pV[p] = v; pO[p] = int'(reqOut[p*NV+v]);
          end
        end
      end
    end
    for (int o = 0; o < NP; o++) begin
      eOv[o] = 0; eOs[o] = 0; eOb[o] = 0; eV[o] = 0; eH[o] = 0; eT[o] = 0;
      for (int c = 1; c >= 0; c--) begin
        for (int k = 0; k < NP; k++) begin
          automatic int q = ((c == 1 ? mOpHi[o] : mOpLo[o]) + k) % NP;
          if (eOv[o] == 0 && pOk[q] && int'(pH[q]) == c && pO[q] == o) begin
            eOv[o] = 1; eOs[o] = q; eV[o] = pV[q]; eH[o] = c; eT[o] = int'(reqTail[q*NV+pV[q]]);
            expVc[q*NV+pV[q]] = 1'b1;
          end
        end
      end
    end
    for (int i = 0; i < NI; i++) begin
      if (reqValid[i]) anyBuf[i / NV] = 1;
      if (mElig(i / NV, i % NV)) bufFor[int'(reqOut[i])] = 1;
    end
    for (int p = 0; p < NP; p++) begin
      automatic int o = int'(arrOut[p]);
      if (arrValid[p] && arrHi[p] && arrCredit[p] && o < NP && !anyBuf[p])
        cand[p] = !bufFor[o] && freeFor(o, p, int'(arrVc[p]));
    end
    for (int o = 0; o < NP; o++) begin
      for (int p = 0; p < NP; p++) begin
        if (eOv[o] == 0 && cand[p] && int'(arrOut[p]) == o) begin
          eOv[o] = 1; eOs[o] = p; eOb[o] = 1; eV[o] = int'(arrVc[p]); eH[o] = 1;
          eT[o] = int'(arrTail[p]);
          expByp[p] = 1'b1;
        end
      end
    end
  endtask

  task automatic modelUpdate();
    for (int o = 0; o < NP; o++) begin
      if (eOv[o] != 0) begin
        mLkV[o] = (eT[o] != 0) ? 0 : 1;
        mLkP[o] = eOs[o];
        mLkC[o] = eV[o];
        if (eOb[o] == 0) begin
          if (eH[o] != 0) begin
            mOpHi[o] = (eOs[o] + 1) % NP; mIpHi[eOs[o]] = (eV[o] + 1) % NV;
          end else begin
            mOpLo[o] = (eOs[o] + 1) % NP; mIpLo[eOs[o]] = (eV[o] + 1) % NV;
          end
        end
      end
    end
  endtask

  task automatic compareAll(string tag);
    int aSrc = 0;
    int xSrc = 0;
    for (int o = 0; o < NP; o++) begin
      if (outValid[o]) aSrc += int'(outSrc[o]) << (4 * o);
      if (eOv[o] != 0) xSrc += eOs[o] << (4 * o);
    end
    check(tag, "vcGnt", int'(vcGnt), int'(expVc));
    check(tag, "bypGnt", int'(bypGnt), int'(expByp));
    begin
      automatic int xv = 0;
      automatic int xb = 0;
      for (int o = 0; o < NP; o++) begin
        xv |= eOv[o] << o;
        xb |= eOb[o] << o;
      end
      check(tag, "outValid", int'(outValid), xv);
      check(tag, "outBypass", int'(outBypass), xb);
    end
    check(tag, "outSrc", aSrc, xSrc);
  endtask

  task automatic clearInputs();
    reqValid = '0; reqHi = '0; reqTail = '0; reqCredit = '0; reqOut = '0;
    arrValid = '0; arrHi = '0; arrTail = '0; arrCredit = '0; arrVc = '0; arrOut = '0;
  endtask

  // mode: 1 illegal codes/credits, 2 one hot output mixed class, 3 low-class
  // contention, 4 long packets, 5 bypass-heavy, 6 anything
  task automatic randInputs(int mode);
    for (int i = 0; i < NI; i++) begin
      reqValid[i] = (mode == 5) ? ($urandom_range(3) == 0) : $urandom_range(1);
      reqOut[i] = (mode == 1) ? PW'($urandom_range(7)) : (mode == 2) ? PW'(2) :
                  (mode == 3) ? PW'($urandom_range(1)) : PW'($urandom_range(NP - 1));
      reqHi[i] = (mode == 3) ? 1'b0 : 1'($urandom_range(1));
      reqTail[i] = (mode == 4) ? ($urandom_range(4) == 0) : 1'($urandom_range(1));
      reqCredit[i] = (mode == 1) ? 1'($urandom_range(1)) : ($urandom_range(7) != 0);
    end
    for (int p = 0; p < NP; p++) begin
      arrValid[p] = (mode >= 5) ? 1'($urandom_range(1)) : 1'b0;
      arrVc[p] = SA_VC_W'($urandom_range(NV - 1));
      arrOut[p] = PW'($urandom_range(NP - 1));
      arrHi[p] = ($urandom_range(3) != 0);
      arrTail[p] = 1'($urandom_range(1));
      arrCredit[p] = ($urandom_range(7) != 0);
    end
  endtask

  task automatic stepCycle(string tag);
    #1;
    modelEval();
    compareAll(tag);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic runPhase(string tag, int mode, int n);
    for (int c = 0; c < n; c++) begin
      randInputs(mode);
      stepCycle(tag);
    end
  endtask

  initial begin
    clearInputs();
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, no requests, no grants
    check("R1", "reset outValid", int'(outValid), 0);
    check("R1", "reset vcGnt", int'(vcGnt), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: pointers start at 0; ports 3 and 1 compete for output 0
    reqValid[3*NV] = 1'b1; reqCredit[3*NV] = 1'b1; reqOut[3*NV] = '0; reqTail[3*NV] = 1'b1;
    reqValid[1*NV] = 1'b1; reqCredit[1*NV] = 1'b1; reqOut[1*NV] = '0; reqTail[1*NV] = 1'b1;
    #1;
    check("R1", "first winner of output 0", int'(outSrc[0]), 1);
    stepCycle("R1");
    // R4: expedited port 4 beats normal port 0 on output 1
    clearInputs();
    reqValid[0] = 1'b1; reqCredit[0] = 1'b1; reqOut[0] = PW'(1); reqTail[0] = 1'b1;
    reqValid[4*NV+2] = 1'b1; reqCredit[4*NV+2] = 1'b1; reqOut[4*NV+2] = PW'(1);
    reqHi[4*NV+2] = 1'b1; reqTail[4*NV+2] = 1'b1;
    #1;
    check("R4", "expedited source on output 1", int'(outSrc[1]), 4);
    stepCycle("R4");
    clearInputs();
    runPhase("R2", 1, 400);
    runPhase("R4", 2, 400);
    runPhase("R5,R6", 3, 400);
    runPhase("R7", 4, 400);
    runPhase("R8,R9", 5, 600);
    runPhase("R3,R10", 6, 600);
    clearInputs();
    stepCycle("R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule